// File: doc/BRIEF.md
# Odd-ones and double-zero detector

This block watches a serial bit stream, taking one bit on each rising clock edge, and raises a flag when two things are both true. The number of 1s taken since reset must be odd. Two 0s in a row must also have appeared at least once since reset. The flag comes from the state register alone, as in a Moore machine, so it can change only just after a clock edge and never follows the input inside a cycle.

Six states cover three facts about the stream: parity, whether one trailing 0 is pending, and whether the 00 pair has ever been seen. Once the pair has been seen, that fact is kept until reset. From then on, 0s no longer matter and each 1 toggles the flag. Reset is synchronous and active high, and it returns the machine to the empty, even-parity state.

Top module: `odd_zero_pair_detector`

## Requirements
- R1: On a clock edge with `rst` high, the machine returns to its initial state (even parity, no 00 seen), and `z_out` reads 0 after that edge.
- R2: After each edge, `z_out` is 1 exactly when the 1s accepted since reset are odd and a 00 pair has appeared since reset. A lone 0 between 1s never counts as a pair.
- R3: Each accepted 1 toggles the parity. An accepted 0 leaves the parity unchanged.
- R4: Once a 00 pair has been seen, further 0s or 1s never clear that condition until reset.
- R5: The flag rises whether the 00 pair comes before parity turns odd or after it.
- R6: `x_in` is sampled only at the rising edge of `clk`. Changes of `x_in` between edges neither move `z_out` nor affect the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is accepted per edge |
| rst | input | 1 | Synchronous active-high reset to the initial state |
| x_in | input | 1 | Serial input bit |
| z_out | output | 1 | 1 when the parity of 1s is odd and a 00 pair has been seen |

## Verification
One stream turns parity odd first and then sends two 0s, and another sends the 00 pair first and then a single 1. The flag must rise in both, which separates a machine that handles only one order from one that handles both. A stream of 0s each separated by 1s must keep the flag low; a design that treats any 0 as a pair would raise it. Long runs of 0s and 1s after the pair show that the pair condition is kept and that only 1s change parity. A pulse on the input between two edges shows that the input is sampled only at the edge.

// File: rtl/odd_zero_pair_detector.sv
module odd_zero_pair_detector (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic z_out
);
  // bit0 = parity of 1s, bit1 = single trailing 0 pending, bit2 = 00 seen
  localparam logic [2:0] ST_IDLE     = 3'b000;
  localparam logic [2:0] ST_ODD      = 3'b001;
  localparam logic [2:0] ST_EVEN_Z   = 3'b010;
  localparam logic [2:0] ST_ODD_Z    = 3'b011;
  localparam logic [2:0] ST_EVEN_HIT = 3'b100;
  localparam logic [2:0] ST_ODD_HIT  = 3'b101;

  logic [2:0] cur_q, nxt;

  always_comb begin
    case (cur_q)
      ST_IDLE:     nxt = x_in ? ST_ODD      : ST_EVEN_Z;
      ST_ODD:      nxt = x_in ? ST_IDLE     : ST_ODD_Z;
      ST_EVEN_Z:   nxt = x_in ? ST_ODD      : ST_EVEN_HIT;
      ST_ODD_Z:    nxt = x_in ? ST_IDLE     : ST_ODD_HIT;
      ST_EVEN_HIT: nxt = x_in ? ST_ODD_HIT  : ST_EVEN_HIT;
      ST_ODD_HIT:  nxt = x_in ? ST_EVEN_HIT : ST_ODD_HIT;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_IDLE;
    else     cur_q <= nxt;
  end

  assign z_out = (cur_q == ST_ODD_HIT);

  p_reset_init_r1: assert property (@(posedge clk) rst |=> (cur_q == ST_IDLE && !z_out))
    else $error("reset did not reach initial state");

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst) cur_q <= ST_ODD_HIT)
    else $error("illegal state code");

  p_one_flips_r3: assert property (@(posedge clk) disable iff (rst) x_in |=> (cur_q[0] != $past(cur_q[0])))
    else $error("1 did not flip parity");

  p_zero_holds_r3: assert property (@(posedge clk) disable iff (rst) !x_in |=> $stable(cur_q[0]))
    else $error("0 changed parity");

  p_seen_sticky_r4: assert property (@(posedge clk) disable iff (rst) cur_q[2] |=> cur_q[2])
    else $error("00 condition lost");

  p_pair_needed_r5: assert property (@(posedge clk) disable iff (rst) $rose(cur_q[2]) |-> (!$past(x_in) && !$past(x_in, 2)))
    else $error("00 condition set without two zeros");
endmodule

// File: tb/odd_zero_pair_detector_tb.sv
module odd_zero_pair_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic z_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  odd_zero_pair_detector dut_i (.clk(clk), .rst(rst), .x_in(x_in), .z_out(z_out));

  // {rst, x, expected z, requirement number}
  localparam int NV = 26;
  localparam logic [5:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 3'd1},  // R1 reset
    {1'b0, 1'b1, 1'b0, 3'd2},  // odd, no pair
    {1'b0, 1'b0, 1'b0, 3'd2},  // odd, one zero
    {1'b0, 1'b0, 1'b1, 3'd5},  // R5 odd first, then 00
    {1'b0, 1'b1, 1'b0, 3'd3},  // R3 parity even
    {1'b0, 1'b0, 1'b0, 3'd4},  // R4 zero keeps pair
    {1'b0, 1'b1, 1'b1, 3'd3},  // R3
    {1'b0, 1'b0, 1'b1, 3'd4},  // R4
    {1'b0, 1'b0, 1'b1, 3'd4},  // R4
    {1'b0, 1'b1, 1'b0, 3'd3},  // R3
    {1'b0, 1'b1, 1'b1, 3'd3},  // R3
    {1'b1, 1'b1, 1'b0, 3'd1},  // R1 reset while flag high
    {1'b0, 1'b0, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b0, 3'd2},  // pair seen, parity even
    {1'b0, 1'b1, 1'b1, 3'd5},  // R5 00 first, then odd
    {1'b1, 1'b0, 1'b0, 3'd1},  // R1
    {1'b0, 1'b0, 1'b0, 3'd2},  // R2 lone zeros
    {1'b0, 1'b1, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b0, 3'd2},
    {1'b0, 1'b1, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b0, 3'd2},
    {1'b0, 1'b1, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b1, 3'd5},
    {1'b0, 1'b1, 1'b0, 3'd3},
    {1'b0, 1'b1, 1'b1, 3'd3}
  };

  task automatic check(input logic exp, input int req, input string what);
    n_chk++;
    if (z_out !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: z_out=%b expected %b", req, what, z_out, exp);
    end
  endtask

  task automatic step(input logic r, input logic x);
    @(negedge clk);
    rst = r;
    x_in = x;
    @(posedge clk);
    #1;
  endtask

  initial begin
    step(1'b1, 1'b0);
    check(1'b0, 1, "initial reset");  // R1
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4]);
      check(VEC[i][3], int'(VEC[i][2:0]), $sformatf("vector %0d", i));
    end
    // R6: state is odd with pair seen; pulse x between edges, hold 0 at edge
    @(negedge clk);
    x_in = 1'b1;
    #0.5;
    check(1'b1, 6, "z moved with x inside cycle");  // R6
    x_in = 1'b0;
    @(posedge clk);
    #1;
    check(1'b1, 6, "mid-cycle pulse taken as a 1");  // R6
    // R4: long zero run keeps flag
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0);
    check(1'b1, 4, "zero run cleared flag");  // R4
    step(1'b1, 1'b1);
    check(1'b0, 1, "final reset");  // R1
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule